// File: doc/BRIEF.md
# Eight-Channel Pulse-Width Modulator with Selectable Resolution

This block drives up to eight output pins with independent pulse-width modulated waveforms. Every channel keeps a duty value, a small control word and an enable bit, all loaded through a simple write-only register bus. The control word chooses the frame length, either 32 or 256 PWM clocks, and a prescaler that derives the PWM clock from the system clock. When a channel's enable bit is clear, its pin simply carries the matching bit of the ordinary port latch.

Each channel counts through its frame. The pin is high while the count is below the active duty value, so a value of zero keeps the pin low and the largest value leaves exactly one low PWM clock per frame. A written duty value waits in the register and is copied into a working copy only when the frame ends. This means a frame never mixes an old and a new value. The prescaler code that would ask for a half-cycle PWM clock cannot be built from the system clock. It is run as divide-by-one and reported on a per-channel flag.

Top module: `pwm_bank`

## Requirements
- R1: After reset every duty value is 0, every control word is 000 and every enable bit is 0. Each pin therefore equals its port latch bit, and every `div_fault` bit is 1.
- R2: While enable bit i (bit i of the word written to address 2*NCH) is 0, `pin_out[i]` equals `port_latch[i]`. While it is 1, the pin carries the PWM waveform of channel i.
- R3: With control bit 2 at 0 (full resolution), a frame lasts 256 PWM clocks and the pin is high for the first D of them. Value 0x80 gives 128 high clocks and 0xFF gives 255.
- R4: A duty value of 0 holds the enabled pin low for the whole frame.
- R5: With control bit 2 at 1 (low resolution), a frame lasts 32 PWM clocks and only duty bits 4:0 count. The frame counter then stays below 32, 0x1F gives 31 high clocks and 0xE5 gives 5.
- R6: Control bits 1:0 select the PWM clock: 01 gives one PWM clock per system clock, 10 gives one per 2 system clocks and 11 gives one per 4 system clocks.
- R7: Prescaler code 00 behaves exactly as code 01, and `div_fault[i]` is 1 exactly while channel i holds code 00.
- R8: A new duty value takes effect only from the next frame boundary, and the working copy never changes inside a frame. A write made in the last system clock of a frame is applied only to the frame after the next.
- R9: Address i (0 to NCH-1) writes the duty value of channel i, and address NCH+i writes the control word of channel i from data bits 2:0. Channels run independently, each with its own prescaler and frame counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe, taken on the rising clock edge |
| wr_addr | input | AW (5) | Register address: duty values, then control words, then the enable word |
| wr_data | input | BUS_W (8) | Write data |
| port_latch | input | NCH (8) | General-purpose port bits used when PWM is disabled |
| pin_out | output | NCH (8) | Pin levels after the PWM/port selection |
| div_fault | output | NCH (8) | Per-channel flag: the unsupported prescaler code 00 is selected |

## Verification
The delicate collision is a duty write that lands on the same clock edge as a frame boundary. On that edge the working copy reloads from the duty register while the register itself takes the new value. The bench locks onto a frame by watching the pin rise, then places a write exactly in the last system clock of that frame, and a second write a few clocks into a frame. It then counts the high clocks of the following frames and expects the old value to persist for one full extra frame in the colliding case but not in the early case.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  localparam int CTRL_W = 3;

  // prescaler selection; HALF cannot be built from the system clock
  typedef enum logic [1:0] {
    DIV_HALF = 2'b00,
    DIV_ONE  = 2'b01,
    DIV_TWO  = 2'b10,
    DIV_FOUR = 2'b11
  } div_sel_e;

  typedef struct packed {
    logic     res_lo;  // 1: short frame, 0: long frame
    div_sel_e div;
  } chan_ctrl_t;

  // terminal count of the prescaler (ticks every limit+1 clocks)
  function automatic logic [1:0] div_limit(div_sel_e d);
    case (d)
      DIV_TWO:  div_limit = 2'd1;
      DIV_FOUR: div_limit = 2'd3;
      default:  div_limit = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_bank_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int DW    = 8,
  parameter int AW    = 5,
  parameter int BUS_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [AW-1:0]                wr_addr,
  input  logic [BUS_W-1:0]             wr_data,
  output logic [NCH-1:0][DW-1:0]       duty_q,
  output chan_ctrl_t [NCH-1:0]         ctrl_q,
  output logic [NCH-1:0]               en_q
);

  logic [NCH-1:0][DW-1:0] duty_d;
  chan_ctrl_t [NCH-1:0]   ctrl_d;
  logic [NCH-1:0]         en_d;

  always_comb begin
    duty_d = duty_q;
    ctrl_d = ctrl_q;
    en_d   = en_q;
    for (int i = 0; i < NCH; i++) begin
      if (wr_en && wr_addr == AW'(i))
        duty_d[i] = wr_data[DW-1:0];
      if (wr_en && wr_addr == AW'(NCH + i))
        ctrl_d[i] = chan_ctrl_t'(wr_data[CTRL_W-1:0]);
    end
    if (wr_en && wr_addr == AW'(2 * NCH))
      en_d = wr_data[NCH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= '0;
      ctrl_q <= '0;
      en_q   <= '0;
    end else begin
      duty_q <= duty_d;
      ctrl_q <= ctrl_d;
      en_q   <= en_d;
    end
  end

endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale
  import pwm_bank_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  div_sel_e div,
  output logic     tick
);

  logic [1:0] cnt_q, cnt_d, limit;

  always_comb begin
    limit = div_limit(div);
    tick  = (cnt_q >= limit);
    cnt_d = tick ? 2'd0 : cnt_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int DW     = 8,
  parameter int RES_LO = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          res_lo,
  input  logic [DW-1:0] duty,
  input  logic          en,
  input  logic          latch_bit,
  output logic          pin,
  output logic          frame_end,
  output logic [DW-1:0] cnt_q,
  output logic [DW-1:0] shadow_q
);

  localparam logic [DW-1:0] LO_MASK = DW'((1 << RES_LO) - 1);

  logic [DW-1:0] cnt_d, shadow_d, mask;
  logic          pwm_hi;

  always_comb begin
    mask      = res_lo ? LO_MASK : '1;
    frame_end = res_lo ? (cnt_q[RES_LO-1:0] == '1) : (cnt_q == '1);
    cnt_d     = cnt_q;
    shadow_d  = shadow_q;
    if (tick) begin
      if (frame_end) begin
        cnt_d    = '0;
        shadow_d = duty;
      end else if (res_lo) begin
        cnt_d = DW'(cnt_q[RES_LO-1:0]) + DW'(1);
      end else begin
        cnt_d = cnt_q + DW'(1);
      end
    end
    pwm_hi = (cnt_q & mask) < (shadow_q & mask);
    pin    = en ? pwm_hi : latch_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      shadow_q <= '0;
    end else begin
      cnt_q    <= cnt_d;
      shadow_q <= shadow_d;
    end
  end

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int  NCH    = 8,
  parameter int  DW     = 8,
  parameter int  RES_LO = 5,
  localparam int AW     = $clog2(2 * NCH + 1),
  localparam int BUS_W  = (DW > NCH) ? DW : NCH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [BUS_W-1:0] wr_data,
  input  logic [NCH-1:0]   port_latch,
  output logic [NCH-1:0]   pin_out,
  output logic [NCH-1:0]   div_fault
);

  logic [1:0] rst_pipe;
  logic       rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  logic [NCH-1:0][DW-1:0] duty_q;
  chan_ctrl_t [NCH-1:0]   ctrl_q;
  logic [NCH-1:0]         en_q;

  pwm_regs #(.NCH(NCH), .DW(DW), .AW(AW), .BUS_W(BUS_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .duty_q  (duty_q),
    .ctrl_q  (ctrl_q),
    .en_q    (en_q)
  );

  logic [NCH-1:0]        tick_vec, last_vec, res_lo_vec;
  logic [2*NCH-1:0]      div_vec;
  logic [NCH*DW-1:0]     cnt_flat, shadow_flat;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign res_lo_vec[i]      = ctrl_q[i].res_lo;
    assign div_vec[2*i +: 2]  = ctrl_q[i].div;
    assign div_fault[i]       = (ctrl_q[i].div == DIV_HALF);

    pwm_prescale u_pre (
      .clk   (clk),
      .rst_n (rst_n_sync),
      .div   (ctrl_q[i].div),
      .tick  (tick_vec[i])
    );

    pwm_channel #(.DW(DW), .RES_LO(RES_LO)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n_sync),
      .tick      (tick_vec[i]),
      .res_lo    (ctrl_q[i].res_lo),
      .duty      (duty_q[i]),
      .en        (en_q[i]),
      .latch_bit (port_latch[i]),
      .pin       (pin_out[i]),
      .frame_end (last_vec[i]),
      .cnt_q     (cnt_flat[i*DW +: DW]),
      .shadow_q  (shadow_flat[i*DW +: DW])
    );
  end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NCH    = 8,
  parameter int DW     = 8,
  parameter int RES_LO = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    port_latch,
  input logic [NCH-1:0]    pin_out,
  input logic [NCH-1:0]    en,
  input logic [NCH-1:0]    res_lo,
  input logic [2*NCH-1:0]  div,
  input logic [NCH-1:0]    tick,
  input logic [NCH-1:0]    last,
  input logic [NCH*DW-1:0] cnt,
  input logic [NCH*DW-1:0] shadow
);

  localparam logic [DW-1:0] LO_MASK = DW'((1 << RES_LO) - 1);
  localparam logic [DW-1:0] LO_SPAN = DW'(1 << RES_LO);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R2
    mux_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en[i] |-> pin_out[i] == port_latch[i]);

    // R4
    zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en[i] && ((shadow[i*DW +: DW] & (res_lo[i] ? LO_MASK : '1)) == '0) |-> !pin_out[i]);

    // R5
    lo_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick[i] && res_lo[i] |=> cnt[i*DW +: DW] < LO_SPAN);

    // R8
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tick[i] && last[i]) |=> $stable(shadow[i*DW +: DW]));

    // R7
    fast_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !div[2*i+1] |-> tick[i]);
  end

endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .DW(DW), .RES_LO(RES_LO)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_sync),
  .port_latch (port_latch),
  .pin_out    (pin_out),
  .en         (en_q),
  .res_lo     (res_lo_vec),
  .div        (div_vec),
  .tick       (tick_vec),
  .last       (last_vec),
  .cnt        (cnt_flat),
  .shadow     (shadow_flat)
);

// File: tb/tb_pwm_bank.sv
`timescale 1ns/1ps
module tb_pwm_bank;

  localparam int NCH = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] port_latch = '0;
  logic [7:0] pin_out;
  logic [7:0] div_fault;

  int checks = 0;
  int errors = 0;
  logic [7:0] en_mask = '0;

  always #5 clk = ~clk;

  pwm_bank dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .port_latch(port_latch), .pin_out(pin_out),
    .div_fault(div_fault)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(addr); wr_data = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic enable_ch(input int ch);
    en_mask[ch] = 1'b1;
    wr(2 * NCH, int'(en_mask));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_high(input int ch, input int n, output int hi);
    hi = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pin_out[ch]) hi++;
    end
  endtask

  task automatic sync_rise(input int ch);
    @(negedge clk);
    while (pin_out[ch]) @(negedge clk);
    while (!pin_out[ch]) @(negedge clk);
  endtask

  task automatic t_reset;
    port_latch = 8'hA5;
    idle(1);
    check(pin_out == 8'hA5, "R1 pins follow latch", pin_out, 8'hA5);
    check(div_fault == 8'hFF, "R1 fault flags", div_fault, 8'hFF);
    port_latch = 8'h5A;
    idle(1);
    check(pin_out == 8'h5A, "R2 disabled pins follow latch", pin_out, 8'h5A);
  endtask

  task automatic t_full_res;
    int hi;
    wr(NCH + 0, 3'b001);
    wr(0, 8'h80);
    enable_ch(0);
    idle(600);
    count_high(0, 256, hi);
    check(hi == 128, "R3 duty 0x80", hi, 128);
    wr(0, 8'hFF);
    idle(600);
    count_high(0, 256, hi);
    check(hi == 255, "R3 duty 0xFF", hi, 255);
    wr(0, 8'h00);
    idle(600);
    count_high(0, 256, hi);
    check(hi == 0, "R4 duty zero", hi, 0);
    port_latch = 8'hFF;
    idle(2);
    check(pin_out == 8'hFE, "R2 enabled pin ignores latch", pin_out, 8'hFE);
  endtask

  task automatic t_low_res;
    int hi;
    wr(NCH + 1, 3'b101);
    wr(1, 8'h1F);
    enable_ch(1);
    idle(100);
    count_high(1, 32, hi);
    check(hi == 31, "R5 duty 0x1F", hi, 31);
    wr(1, 8'hE5);
    idle(100);
    count_high(1, 32, hi);
    check(hi == 5, "R5 upper bits masked", hi, 5);
  endtask

  task automatic t_prescale;
    int hi;
    wr(NCH + 3, 3'b010);
    wr(3, 8'h40);
    enable_ch(3);
    idle(1100);
    count_high(3, 512, hi);
    check(hi == 128, "R6 divide by 2", hi, 128);
    wr(NCH + 3, 3'b111);
    wr(3, 8'h03);
    idle(300);
    count_high(3, 128, hi);
    check(hi == 12, "R6 divide by 4", hi, 12);
  endtask

  task automatic t_code00;
    int hi;
    wr(NCH + 4, 3'b100);
    wr(4, 8'h07);
    enable_ch(4);
    idle(100);
    check(div_fault[4] == 1'b1, "R7 flag set", div_fault[4], 1);
    count_high(4, 32, hi);
    check(hi == 7, "R7 code 00 as divide by 1", hi, 7);
    wr(NCH + 4, 3'b101);
    idle(2);
    check(div_fault[4] == 1'b0, "R7 flag clear", div_fault[4], 0);
  endtask

  task automatic t_independent;
    int hi;
    wr(NCH + 6, 3'b011);
    wr(6, 8'hC0);
    wr(NCH + 7, 3'b110);
    wr(7, 8'h09);
    enable_ch(6);
    enable_ch(7);
    idle(2100);
    count_high(6, 1024, hi);
    check(hi == 768, "R9 channel 6", hi, 768);
    count_high(7, 64, hi);
    check(hi == 18, "R9 channel 7", hi, 18);
    count_high(1, 32, hi);
    check(hi == 5, "R9 channel 1 undisturbed", hi, 5);
    check(div_fault == 8'h24, "R9 per-channel fault flags", div_fault, 8'h24);
  endtask

  task automatic t_shadow_mid;
    int fr [2];
    wr(NCH + 2, 3'b101);
    wr(2, 8'd10);
    enable_ch(2);
    idle(100);
    sync_rise(2);
    fr[0] = 0; fr[1] = 0;
    for (int k = 0; k < 64; k++) begin
      if (k > 0) @(negedge clk);
      if (pin_out[2]) fr[k / 32]++;
      if (k == 3) begin wr_en = 1'b1; wr_addr = 5'd2; wr_data = 8'd20; end
      if (k == 4) wr_en = 1'b0;
    end
    check(fr[0] == 10, "R8 mid-frame write keeps frame", fr[0], 10);
    check(fr[1] == 20, "R8 new value next frame", fr[1], 20);
  endtask

  task automatic t_shadow_edge;
    int fr [3];
    sync_rise(2);
    fr[0] = 0; fr[1] = 0; fr[2] = 0;
    for (int k = 0; k < 96; k++) begin
      if (k > 0) @(negedge clk);
      if (pin_out[2]) fr[k / 32]++;
      if (k == 31) begin wr_en = 1'b1; wr_addr = 5'd2; wr_data = 8'd6; end
      if (k == 32) wr_en = 1'b0;
    end
    check(fr[0] == 20, "R8 edge write frame 0", fr[0], 20);
    check(fr[1] == 20, "R8 edge write old value kept", fr[1], 20);
    check(fr[2] == 6, "R8 edge write applied late", fr[2], 6);
  endtask

  bit done = 1'b0;

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_full_res();
    t_low_res();
    t_prescale();
    t_code00();
    t_independent();
    t_shadow_mid();
    t_shadow_edge();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule